// File: doc/BRIEF.md
# Six-Output Shared-Period PWM Timer

This block is a memory-mapped pulse-width modulation timer. One up-counter and one clock prescaler are shared by six compare channels. The modulo register sets the common period, and each channel compares the running count against its own compare value to drive one output pin. Every output therefore runs at the same frequency, and each output has its own duty cycle, polarity and enable.

Software reaches the block over a simple register bus. A write is accepted in any cycle in which `bus_we` is high. Read data is combinational and follows `bus_addr` in the same cycle. A run-state machine has two states, `CNT_STOPPED` and `CNT_RUNNING`. It takes the transition START when the clock-mode field becomes 01 and the transition HALT when the field takes any other value.

In `CNT_STOPPED`, writes to the modulo and compare registers take effect at once. In `CNT_RUNNING`, those writes wait in a buffer and are copied to the active registers when the counter wraps, so no period is ever cut short.

Top module: `pwm_sixch_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and all six outputs are 0.
- R2: The global control register sits at offset 0x10. Bits 2:0 hold the prescale exponent PS and bits 4:3 hold the clock mode. Bit 5 and every higher bit always read 0. The counter advances only when the clock mode is 01. Any other mode holds the count.
- R3: While running, the counter at offset 0x14 advances by one every 2^PS clocks. It wraps from the active modulo value to 0 and never exceeds the modulo value.
- R4: Any write to the counter register sets the count to 0 and restarts the prescaler.
- R5: The modulo register sits at offset 0x18, and channel n's compare register sits at 0x24+8n. A write to either register while the counter is stopped takes effect on the outputs at once.
- R6: A write to the modulo or compare register while the counter is running changes nothing until the next wrap, where both are loaded. Reads always return the last value written.
- R7: Channel n's control register sits at offset 0x20+8n. Bit 7 is the flag, bit 5 is mode-select B, bit 4 is mode-select A, bit 3 is edge-select B and bit 2 is edge-select A. Bits 6, 1 and 0 read 0.
- R8: Edge-aligned PWM is selected by mode bits B=1 and A=0. With edge-select B set and edge-select A clear (normal polarity), the output is 1 exactly while count < compare.
- R9: With edge-select A set and edge-select B clear, the output is the complement of the normal output. With both edge-select bits set, the channel behaves as normal polarity.
- R10: A channel output is held at 0 when both edge-select bits are 0, or when the mode bits are not B=1, A=0.
- R11: A compare value of 0 gives a constant low normal output. A compare value above the modulo value gives a constant high normal output.
- R12: The flag sets on any prescaled count step taken while the count equals the compare value. Writing 1 to bit 7 clears it. Writing 0 to bit 7 leaves it unchanged. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 6 | Channel outputs, bit n belongs to channel n |

## Verification
Both the count and the outputs can be seen through the ports, so a wrong internal state shows up quickly. If the run-state register or the prescaler is wrong, the counter read back at offset 0x14 takes a wrong step or holds for the wrong number of cycles, and this shows within one prescaled period. If the active compare or modulo value is loaded at the wrong moment, `pwm_out` disagrees with the count-versus-compare model in the first cycle after the faulty load, which is at most one period away. A flag that is set or cleared wrongly appears in the next read of that channel's control register.

// File: rtl/pwm6_pkg.sv
`timescale 1ns/1ps
package pwm6_pkg;
    // register offsets decoded by software
    localparam int OFF_CTRL    = 'h10;
    localparam int OFF_COUNT   = 'h14;
    localparam int OFF_PERIOD  = 'h18;
    localparam int OFF_CH_CTL  = 'h20;
    localparam int OFF_CH_VAL  = 'h24;
    localparam int CH_STRIDE   = 8;

    localparam logic [1:0] MODE_EVERY = 2'b01;

    typedef enum logic {
        CNT_STOPPED = 1'b0,
        CNT_RUNNING = 1'b1
    } cnt_state_e;

    // channel configuration, packed in the order of control bits 5:2
    typedef struct packed {
        logic ms_b;
        logic ms_a;
        logic el_b;
        logic el_a;
    } ch_cfg_t;
endpackage

// File: rtl/pwm6_prescale.sv
`timescale 1ns/1ps
module pwm6_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] limit;

    assign limit = DIV_W'((32'd1 << ps) - 32'd1);
    assign tick  = run && (pre_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm6_count_core.sv
`timescale 1ns/1ps
module pwm6_count_core
    import pwm6_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_mode,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic             running,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] per_buf
);
    cnt_state_e state_q;
    cnt_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_STOPPED: if (clk_mode == MODE_EVERY) state_d = CNT_RUNNING;
            CNT_RUNNING: if (clk_mode != MODE_EVERY) state_d = CNT_STOPPED;
            default:     state_d = CNT_STOPPED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        running = (state_q == CNT_RUNNING);
        wrap    = tick && (cnt == per_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_buf <= '0;
            per_act <= '0;
        end else begin
            if (per_wr) per_buf <= wr_val;
            if (per_wr && !running) begin
                per_act <= wr_val;
            end else if (wrap) begin
                per_act <= per_buf;
            end
        end
    end
endmodule

// File: rtl/pwm6_channel.sv
`timescale 1ns/1ps
module pwm6_channel
    import pwm6_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ctl_wr,
    input  logic             val_wr,
    input  logic [7:0]       ctl_wdata,
    input  logic [CNT_W-1:0] val_wdata,
    output logic             pwm,
    output logic [7:0]       ctl_rd,
    output logic [CNT_W-1:0] val_rd
);
    ch_cfg_t          cfg_q;
    logic             flag_q;
    logic [CNT_W-1:0] cv_buf;
    logic [CNT_W-1:0] cv_act;
    logic             hit;
    logic             edge_mode;
    logic             enable;
    logic             invert;
    logic             below;
    logic             unused_ctl;

    assign unused_ctl = ^{ctl_wdata[6], ctl_wdata[1:0]};
    assign hit        = tick && (cnt == cv_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctl_wr) cfg_q <= ch_cfg_t'(ctl_wdata[5:2]);
            if (hit) begin
                flag_q <= 1'b1;
            end else if (ctl_wr && ctl_wdata[7]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_buf <= '0;
            cv_act <= '0;
        end else begin
            if (val_wr) cv_buf <= val_wdata;
            if (val_wr && !running) begin
                cv_act <= val_wdata;
            end else if (wrap) begin
                cv_act <= cv_buf;
            end
        end
    end

    always_comb begin
        edge_mode = cfg_q.ms_b && !cfg_q.ms_a;
        enable    = edge_mode && (cfg_q.el_b || cfg_q.el_a);
        invert    = cfg_q.el_a && !cfg_q.el_b;
        below     = (cnt < cv_act);
        pwm       = enable && (below ^ invert);
        ctl_rd    = {flag_q, 1'b0, cfg_q.ms_b, cfg_q.ms_a, cfg_q.el_b, cfg_q.el_a, 2'b00};
        val_rd    = cv_buf;
    end
endmodule

// File: rtl/pwm_sixch_timer.sv
`timescale 1ns/1ps
module pwm_sixch_timer
    import pwm6_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int MODE_LSB = PS_W;

    logic [1:0]      mode_q;
    logic [PS_W-1:0] ps_q;
    logic            ctrl_hit;
    logic            cnt_hit;
    logic            per_hit;
    logic            cnt_wr;
    logic            per_wr;
    logic            tick;
    logic            running;
    logic            wrap;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] per_buf;
    logic [NUM_CH-1:0] ch_ctl_hit;
    logic [NUM_CH-1:0] ch_val_hit;
    logic [NUM_CH-1:0][7:0]       ch_ctl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_val_rd;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    assign ctrl_hit = (bus_addr == ADDR_W'(OFF_CTRL));
    assign cnt_hit  = (bus_addr == ADDR_W'(OFF_COUNT));
    assign per_hit  = (bus_addr == ADDR_W'(OFF_PERIOD));
    assign cnt_wr   = bus_we && cnt_hit;
    assign per_wr   = bus_we && per_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            ps_q   <= '0;
        end else if (bus_we && ctrl_hit) begin
            mode_q <= bus_wdata[MODE_LSB+1:MODE_LSB];
            ps_q   <= bus_wdata[PS_W-1:0];
        end
    end

    pwm6_prescale #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (cnt_wr),
        .ps      (ps_q),
        .tick    (tick)
    );

    pwm6_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_mode (mode_q),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .per_wr   (per_wr),
        .wr_val   (bus_wdata[CNT_W-1:0]),
        .running  (running),
        .wrap     (wrap),
        .cnt      (cnt_val),
        .per_act  (per_act),
        .per_buf  (per_buf)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_ctl_hit[n] = (bus_addr == ADDR_W'(OFF_CH_CTL + CH_STRIDE * n));
        assign ch_val_hit[n] = (bus_addr == ADDR_W'(OFF_CH_VAL + CH_STRIDE * n));

        pwm6_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .running   (running),
            .tick      (tick),
            .wrap      (wrap),
            .cnt       (cnt_val),
            .ctl_wr    (bus_we && ch_ctl_hit[n]),
            .val_wr    (bus_we && ch_val_hit[n]),
            .ctl_wdata (bus_wdata[7:0]),
            .val_wdata (bus_wdata[CNT_W-1:0]),
            .pwm       (pwm_out[n]),
            .ctl_rd    (ch_ctl_rd[n]),
            .val_rd    (ch_val_rd[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) bus_rdata = DATA_W'({mode_q, ps_q});
        if (cnt_hit)  bus_rdata = DATA_W'(cnt_val);
        if (per_hit)  bus_rdata = DATA_W'(per_buf);
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_ctl_hit[n]) bus_rdata = DATA_W'(ch_ctl_rd[n]);
            if (ch_val_hit[n]) bus_rdata = DATA_W'(ch_val_rd[n]);
        end
    end
endmodule

// File: rtl/pwm_timer_checker.sv
`timescale 1ns/1ps
module pwm_timer_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CNT_W-1:0]       cnt,
    input logic [CNT_W-1:0]       per_act,
    input logic                   tick,
    input logic                   cnt_wr,
    input logic                   running,
    input logic [NUM_CH-1:0]      pwm_out,
    input logic [NUM_CH-1:0][7:0] ch_ctl
);
    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == per_act) |=> (cnt == '0));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != per_act && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt));

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R10
        out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctl[n][3:2] == 2'b00) |-> !pwm_out[n]);

        // R12
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ctl[n][7]) |-> $past(tick));
    end
endmodule

bind pwm_sixch_timer pwm_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_val),
    .per_act (per_act),
    .tick    (tick),
    .cnt_wr  (cnt_wr),
    .running (running),
    .pwm_out (pwm_out),
    .ch_ctl  (ch_ctl_rd)
);

// File: tb/sim_pwm_sixch_timer.sv
`timescale 1ns/1ps
module sim_pwm_sixch_timer;
    localparam int A_CTRL = 'h10;
    localparam int A_CNT  = 'h14;
    localparam int A_PER  = 'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    // bench model of the channel set-up
    int m_cv[6];
    int m_pol[6];   // 0 normal, 1 inverted, 2 off
    int m_per;
    bit pend;
    int n_cv0;
    int n_per;

    always #2 clk = ~clk;

    pwm_sixch_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int ch_ctl_a(int n); return 'h20 + 8 * n; endfunction
    function automatic int ch_val_a(int n); return 'h24 + 8 * n; endfunction

    function void check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // monitor: pops one expected read per cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
        end
    end

    task automatic bus_write(input int a, input int d);
        @(posedge clk); #1;
        bus_addr = 8'(a); bus_wdata = 32'(d); bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = 8'(a);
        it.exp = 32'(e); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic peek(input int a, output int v);
        @(posedge clk); #1;
        bus_addr = 8'(a);
        @(negedge clk);
        v = int'(bus_rdata);
    endtask

    task automatic pin_chk(input int idx, input bit e, input string tag);
        @(posedge clk); #1;
        @(negedge clk);
        check(tag, 32'(pwm_out[idx]), 32'(e));
    endtask

    function automatic logic [5:0] model_out(int c);
        logic [5:0] r;
        for (int n = 0; n < 6; n++) begin
            case (m_pol[n])
                0:       r[n] = (c < m_cv[n]);
                1:       r[n] = !(c < m_cv[n]);
                default: r[n] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // cycle-by-cycle watch of count and outputs
    task automatic watch(input int cycles, input int div);
        int prev = -1;
        int run = 0;
        int nchg = 0;
        for (int i = 0; i < cycles; i++) begin
            int c;
            bit wrapped;
            @(posedge clk); #1;
            bus_addr = 8'(A_CNT);
            @(negedge clk);
            c = int'(bus_rdata);
            if (prev >= 0 && c != prev) begin
                wrapped = (c == 0 && prev == m_per);
                check("R3 count step", 32'(c), wrapped ? 32'd0 : 32'(prev + 1));
                if (nchg > 0) check("R3 R5 prescale hold", 32'(run), 32'(div));
                nchg++;
                run = 1;
                if (wrapped && pend) begin
                    m_cv[0] = n_cv0; m_per = n_per; pend = 1'b0;
                end
            end else begin
                run++;
            end
            check("R3 bound", 32'(c <= m_per), 32'd1);
            check("R8 R9 R10 R11 R6 outputs", 32'(pwm_out), 32'(model_out(c)));
            prev = c;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        end
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_CTRL, 0, "R1 ctrl");
        rd_chk(A_CNT, 0, "R1 count");
        rd_chk(A_PER, 0, "R1 period");
        rd_chk(ch_ctl_a(0), 0, "R1 ch0 ctl");
        rd_chk(ch_val_a(5), 0, "R1 ch5 val");
        pin_chk(0, 1'b0, "R1 out0");
        @(negedge clk) check("R1 all outputs", 32'(pwm_out), 0);

        // R2 field layout, bit 5 never stored
        bus_write(A_CTRL, 'hFF);
        rd_chk(A_CTRL, 'h1F, "R2 ctrl readback");
        bus_write(A_CTRL, 0);

        // R5 immediate updates while stopped (count is 0)
        bus_write(A_PER, 9);
        bus_write(ch_val_a(0), 3);
        bus_write(ch_ctl_a(0), 'h28);
        pin_chk(0, 1'b1, "R5 R8 stopped compare write");
        bus_write(ch_val_a(0), 0);
        pin_chk(0, 1'b0, "R11 zero compare");
        bus_write(ch_val_a(0), 3);

        bus_write(ch_val_a(1), 3);  bus_write(ch_ctl_a(1), 'h24);
        bus_write(ch_val_a(2), 20); bus_write(ch_ctl_a(2), 'h28);
        bus_write(ch_val_a(3), 0);  bus_write(ch_ctl_a(3), 'h28);
        bus_write(ch_val_a(4), 5);  bus_write(ch_ctl_a(4), 'h0C);
        bus_write(ch_val_a(5), 5);  bus_write(ch_ctl_a(5), 'hFF);
        rd_chk(ch_ctl_a(4), 'h0C, "R7 ch4 ctl layout");
        rd_chk(ch_ctl_a(5), 'h3C, "R7 reserved bits read 0");
        bus_write(ch_ctl_a(5), 'h20);
        m_cv  = '{3, 3, 20, 0, 5, 5};
        m_pol = '{0, 1, 0, 0, 2, 2};
        m_per = 9;
        pend  = 1'b0;

        // run with divide by 1
        bus_write(A_CTRL, 'h08);
        watch(40, 1);
        rd_chk(ch_ctl_a(0), 'hA8, "R12 flag set on match");

        // R6 buffered updates while running
        for (int k = 0; k < 40; k++) begin
            peek(A_CNT, v);
            if (v == 1) break;
        end
        bus_write(A_PER, 14);
        bus_write(ch_val_a(0), 6);
        n_per = 14; n_cv0 = 6; pend = 1'b1;
        watch(50, 1);
        check("R6 buffer loaded at wrap", 32'(pend), 0);
        rd_chk(A_PER, 14, "R6 period readback");
        rd_chk(ch_val_a(0), 6, "R6 compare readback");

        // R2 mode 10 holds count
        bus_write(A_CTRL, 'h10);
        peek(A_CNT, v);
        repeat (12) @(posedge clk);
        rd_chk(A_CNT, v, "R2 mode 10 holds count");
        rd_chk(A_CTRL, 'h10, "R2 mode readback");

        // R4 counter write clears, with divide by 4
        bus_write(A_CTRL, 'h0A);
        repeat (10) @(posedge clk);
        bus_write(A_CNT, 'h1234);
        rd_chk(A_CNT, 0, "R4 count write clears");
        watch(60, 4);

        // R12 flag write-one-to-clear while stopped
        bus_write(A_CTRL, 0);
        repeat (3) @(posedge clk);
        rd_chk(ch_ctl_a(0), 'hA8, "R12 flag before clear");
        bus_write(ch_ctl_a(0), 'h28);
        rd_chk(ch_ctl_a(0), 'hA8, "R12 write 0 keeps flag");
        bus_write(ch_ctl_a(0), 'hA8);
        rd_chk(ch_ctl_a(0), 'h28, "R12 write 1 clears flag");

        // R9 both edge bits act as normal polarity
        bus_write(ch_ctl_a(1), 'h2C);
        peek(A_CNT, v);
        pin_chk(1, v < 3, "R9 both edge bits");

        // R10 wrong mode bits disable the output
        bus_write(ch_ctl_a(2), 'h38);
        pin_chk(2, 1'b0, "R10 mode bits off");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end
endmodule